// File: doc/BRIEF.md
# Copyback/Write-Through Cache Line Controller

This block keeps the coherence state of a single cache line and runs the memory sequence that each processor operation needs on it. An operation arrives as a one-cycle request carrying its kind (read, write, invalidate, push, push-and-invalidate), the tag-compare hit flag and a per-access mode bit that selects copyback or write-through. The controller then drives line fills from memory, single-word memory writes, writes into the cache data storage and data return to the processor. When a dirty line has to be evicted it is parked in a one-entry push buffer and written back only after the new line has arrived.

Tag storage, the data RAM itself and the bus protocol sit outside. The data RAM is seen through a combinational read port and a write strobe. Memory is seen through a read port and a write port, each a held request that completes on an acknowledge. The surrounding logic waits for `busy` to be low, presents a request, and sees `done` when the whole sequence, write-back included, has finished.

Top module: `cache_line_ctrl`

## Requirements
- R1: After reset the line is Invalid (`line_state` = 2'b00, bit 1 = valid, bit 0 = modified), and `busy`, `done`, `mem_rd_req` and `mem_wr_req` are all low.
- R2: A read (`req_op` = 0) that misses on an Invalid or Valid (2'b10) line fetches words 0,1,2,3 in that order and writes each into the cache. It returns the requested word from the fetched data with one `rd_valid` pulse, makes no memory write, and leaves the line Valid.
- R3: A read that hits a valid line returns the cache word at `req_word` with one `rd_valid` pulse, causes no memory traffic and leaves the line state unchanged.
- R4: A copyback (`req_copyback` = 1) write (`req_op` = 1) that misses on an Invalid or Valid line fetches the four words, puts the write data in place of the addressed word, makes no memory write and leaves the line Modified (2'b11).
- R5: A write-through write miss makes exactly one single-word memory write (`mem_wr_line` = 0) of the write data at `req_word`, writes nothing into the cache and leaves the line state unchanged, Modified included.
- R6: A copyback write hit writes only the cache word, causes no memory traffic and leaves the line Modified.
- R7: A write-through write hit writes the word to memory and to the cache and leaves the line Valid, including when the line was Modified.
- R8: A read miss on a Modified line copies the old line into the push buffer, fetches and returns the new data, and only then writes the four old words 0..3 to memory with `mem_wr_line` = 1; the line ends Valid.
- R9: A copyback write miss on a Modified line evicts through the push buffer, fetches the new line with the write merged, then drains the four old words to memory; the line stays Modified.
- R10: Invalidate (`req_op` = 2) makes the line Invalid with no memory read or write, discarding modified data.
- R11: Push (`req_op` = 3) and push-and-invalidate (`req_op` = 4) write the four words of a Modified line to memory as a line write and end Valid and Invalid respectively. On a clean or Invalid line neither touches memory; push keeps the state, push-and-invalidate ends Invalid.
- R12: A request is taken only while `busy` is low; one arriving while busy is ignored. `done` is high for exactly one cycle at the end of every sequence, after any write-back. The line state changes only in the cycle following `done`. Memory requests are held with a stable word index until acknowledged, and reads and writes are never requested together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request, taken when idle |
| req_op | input | 3 | 0 read, 1 write, 2 invalidate, 3 push, 4 push-and-invalidate |
| req_hit | input | 1 | Tag compare hit |
| req_copyback | input | 1 | 1 copyback, 0 write-through for this access |
| req_word | input | IDX_W | Word index inside the line |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read data return strobe |
| rd_data | output | DATA_W | Returned read data |
| line_state | output | 2 | {valid, modified} |
| mem_rd_req | output | 1 | Memory line-fill word request |
| mem_rd_word | output | IDX_W | Word index of the fill request |
| mem_rd_data | input | DATA_W | Fill data from memory |
| mem_rd_ack | input | 1 | Fill word accepted |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_line | output | 1 | 1 for a push-buffer line write, 0 for a single word |
| mem_wr_word | output | IDX_W | Word index of the write |
| mem_wr_data | output | DATA_W | Write data to memory |
| mem_wr_ack | input | 1 | Memory write accepted |
| cram_rd_word | output | IDX_W | Cache data read index |
| cram_rd_data | input | DATA_W | Cache data read value (combinational) |
| cram_wr_en | output | 1 | Cache data write strobe |
| cram_wr_word | output | IDX_W | Cache data write index |
| cram_wr_data | output | DATA_W | Cache data write value |

## Verification
The bench goes after the dirty-eviction orderings. A design that drained the push buffer before the fill, or pushed the freshly fetched line instead of the victim, would show write-back data or timing that does not match the old line. It probes the write-through hit on a Modified line, where a design that kept the line Modified would later lose or duplicate a write-back. It also probes the write-through miss, where allocating the line or touching the cache corrupts a word. Clean pushes, a discarding invalidate and a request arriving mid-sequence are checked for stray memory writes, a wrong final state or a second `done` pulse.

// File: rtl/clc_pkg.sv
package clc_pkg;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_WRITE   = 3'd1,
    OP_INVAL   = 3'd2,
    OP_PUSH    = 3'd3,
    OP_PUSHINV = 3'd4
  } op_e;

  // {valid, modified}
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_VAL = 2'b10,
    LS_MOD = 2'b11
  } lstate_e;

  // Order of the values is the order of the stages in a sequence.
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_COPY  = 3'd1,
    SQ_FILL  = 3'd2,
    SQ_SWR   = 3'd3,
    SQ_CWR   = 3'd4,
    SQ_RET   = 3'd5,
    SQ_DRAIN = 3'd6,
    SQ_FIN   = 3'd7
  } seq_e;

  typedef struct packed {
    logic    push;   // victim copy to push buffer, drain at end
    logic    fill;   // fetch whole line
    logic    merge;  // put write data over the addressed fill word
    logic    swr;    // single-word memory write
    logic    cwr;    // single-word cache write
    logic    ret;    // return data to processor
    lstate_e nxt;    // line state at the end
  } plan_t;

endpackage

// File: rtl/clc_plan.sv
module clc_plan
  import clc_pkg::*;
(
  input  logic [2:0] op,
  input  logic       hit,
  input  logic       copyback,
  input  lstate_e    cur,
  output plan_t      plan
);

  logic valid;
  logic dirty;
  logic ehit;

  assign valid = cur[1];
  assign dirty = cur[1] & cur[0];
  assign ehit  = hit & valid;

  always_comb begin
    plan = '{push: 1'b0, fill: 1'b0, merge: 1'b0, swr: 1'b0,
             cwr: 1'b0, ret: 1'b0, nxt: cur};
    case (op)
      OP_READ: begin
        plan.ret = 1'b1;
        if (!ehit) begin
          plan.fill = 1'b1;
          plan.push = dirty;
          plan.nxt  = LS_VAL;
        end
      end
      OP_WRITE: begin
        if (copyback) begin
          if (ehit) begin
            plan.cwr = 1'b1;
          end else begin
            plan.fill  = 1'b1;
            plan.merge = 1'b1;
            plan.push  = dirty;
          end
          plan.nxt = LS_MOD;
        end else begin
          plan.swr = 1'b1;
          if (ehit) begin
            plan.cwr = 1'b1;
            plan.nxt = LS_VAL;
          end
        end
      end
      OP_INVAL: begin
        plan.nxt = LS_INV;
      end
      OP_PUSH: begin
        plan.push = dirty;
        if (dirty) plan.nxt = LS_VAL;
      end
      OP_PUSHINV: begin
        plan.push = dirty;
        plan.nxt  = LS_INV;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/clc_line_state.sv
module clc_line_state
  import clc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    we,
  input  lstate_e d,
  output lstate_e q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= LS_INV;
    end else if (we) begin
      q <= d;
    end
  end

endmodule

// File: rtl/clc_push_buf.sv
module clc_push_buf #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic              en;
    logic [DATA_W-1:0] q;
    assign en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (en) begin
        q <= wr_data;
      end
    end
    assign words[g] = q;
  end

  assign rd_data = words[rd_idx];

endmodule

// File: rtl/clc_seq.sv
module clc_seq
  import clc_pkg::*;
#(
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(WORDS),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  plan_t            plan,
  input  logic             rd_ack,
  input  logic             wr_ack,
  output seq_e             stage,
  output logic [IDX_W-1:0] cnt,
  output plan_t            pl_q
);

  seq_e             stage_nxt;
  logic             cnt_inc;
  logic             cnt_clr;
  logic             pl_en;
  logic [IDX_W-1:0] cnt_nxt;

  // Next stage of the sequence after stage s, given its plan.
  function automatic seq_e after_stage(seq_e s, plan_t f);
    seq_e r;
    r = SQ_FIN;
    if (s < SQ_DRAIN && f.push)          r = SQ_DRAIN;
    if (s < SQ_RET   && f.ret)           r = SQ_RET;
    if (s < SQ_CWR   && f.cwr && !f.swr) r = SQ_CWR;
    if (s < SQ_SWR   && f.swr)           r = SQ_SWR;
    if (s < SQ_FILL  && f.fill)          r = SQ_FILL;
    if (s < SQ_COPY  && f.push)          r = SQ_COPY;
    return r;
  endfunction

  always_comb begin
    stage_nxt = stage;
    cnt_inc   = 1'b0;
    cnt_clr   = 1'b0;
    case (stage)
      SQ_IDLE: begin
        if (start) stage_nxt = after_stage(SQ_IDLE, plan);
      end
      SQ_COPY: begin
        cnt_inc = 1'b1;
        if (cnt == LAST) begin
          cnt_clr   = 1'b1;
          stage_nxt = after_stage(SQ_COPY, pl_q);
        end
      end
      SQ_FILL: begin
        if (rd_ack) begin
          cnt_inc = 1'b1;
          if (cnt == LAST) begin
            cnt_clr   = 1'b1;
            stage_nxt = after_stage(SQ_FILL, pl_q);
          end
        end
      end
      SQ_SWR: begin
        if (wr_ack) stage_nxt = after_stage(SQ_SWR, pl_q);
      end
      SQ_CWR, SQ_RET: begin
        stage_nxt = after_stage(stage, pl_q);
      end
      SQ_DRAIN: begin
        if (wr_ack) begin
          cnt_inc = 1'b1;
          if (cnt == LAST) begin
            cnt_clr   = 1'b1;
            stage_nxt = SQ_FIN;
          end
        end
      end
      default: begin
        stage_nxt = SQ_IDLE;
      end
    endcase
  end

  assign pl_en   = start && (stage == SQ_IDLE);
  assign cnt_nxt = cnt_clr ? '0 : (cnt + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= SQ_IDLE;
      cnt   <= '0;
      pl_q  <= '{push: 1'b0, fill: 1'b0, merge: 1'b0, swr: 1'b0,
                 cwr: 1'b0, ret: 1'b0, nxt: LS_INV};
    end else begin
      stage <= stage_nxt;
      if (cnt_inc || cnt_clr) cnt <= cnt_nxt;
      if (pl_en) pl_q <= plan;
    end
  end

endmodule

// File: rtl/cache_line_ctrl.sv
module cache_line_ctrl
  import clc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W     = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic              req_hit,
  input  logic              req_copyback,
  input  logic [IDX_W-1:0]  req_word,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        line_state,
  output logic              mem_rd_req,
  output logic [IDX_W-1:0]  mem_rd_word,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_ack,
  output logic              mem_wr_req,
  output logic              mem_wr_line,
  output logic [IDX_W-1:0]  mem_wr_word,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  output logic [IDX_W-1:0]  cram_rd_word,
  input  logic [DATA_W-1:0] cram_rd_data,
  output logic              cram_wr_en,
  output logic [IDX_W-1:0]  cram_wr_word,
  output logic [DATA_W-1:0] cram_wr_data
);

  lstate_e           cur_state;
  plan_t             plan;
  plan_t             pl_q;
  seq_e              stage;
  logic [IDX_W-1:0]  cnt;
  logic              accept;
  logic [IDX_W-1:0]  word_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] ret_q;
  logic [DATA_W-1:0] ret_nxt;
  logic              ret_en;
  logic              in_fill;
  logic              in_drain;
  logic              fill_hit_word;
  logic [DATA_W-1:0] pb_rd_data;

  assign accept        = req_valid && (stage == SQ_IDLE);
  assign in_fill       = (stage == SQ_FILL);
  assign in_drain      = (stage == SQ_DRAIN);
  assign fill_hit_word = (cnt == word_q);

  clc_plan u_plan (
    .op       (req_op),
    .hit      (req_hit),
    .copyback (req_copyback),
    .cur      (cur_state),
    .plan     (plan)
  );

  clc_seq #(.WORDS(LINE_WORDS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (req_valid),
    .plan   (plan),
    .rd_ack (mem_rd_ack),
    .wr_ack (mem_wr_ack),
    .stage  (stage),
    .cnt    (cnt),
    .pl_q   (pl_q)
  );

  clc_line_state u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (stage == SQ_FIN),
    .d     (pl_q.nxt),
    .q     (cur_state)
  );

  clc_push_buf #(.DATA_W(DATA_W), .WORDS(LINE_WORDS)) u_pbuf (
    .clk     (clk),
    .wr_en   (stage == SQ_COPY),
    .wr_idx  (cnt),
    .wr_data (cram_rd_data),
    .rd_idx  (cnt),
    .rd_data (pb_rd_data)
  );

  // Return data: cache word at accept (hit), fetched word during fill (miss).
  always_comb begin
    ret_en  = 1'b0;
    ret_nxt = cram_rd_data;
    if (accept) begin
      ret_en = 1'b1;
    end else if (in_fill && mem_rd_ack && fill_hit_word) begin
      ret_en  = 1'b1;
      ret_nxt = mem_rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      wdata_q <= '0;
      ret_q   <= '0;
    end else begin
      if (accept) begin
        word_q  <= req_word;
        wdata_q <= req_wdata;
      end
      if (ret_en) ret_q <= ret_nxt;
    end
  end

  assign busy       = (stage != SQ_IDLE);
  assign done       = (stage == SQ_FIN);
  assign rd_valid   = (stage == SQ_RET);
  assign rd_data    = ret_q;
  assign line_state = cur_state;

  assign mem_rd_req  = in_fill;
  assign mem_rd_word = cnt;

  assign mem_wr_req  = (stage == SQ_SWR) || in_drain;
  assign mem_wr_line = in_drain;
  assign mem_wr_word = in_drain ? cnt : word_q;
  assign mem_wr_data = in_drain ? pb_rd_data : wdata_q;

  assign cram_rd_word = (stage == SQ_IDLE) ? req_word : cnt;

  assign cram_wr_en   = (in_fill && mem_rd_ack) ||
                        (stage == SQ_CWR) ||
                        ((stage == SQ_SWR) && mem_wr_ack && pl_q.cwr);
  assign cram_wr_word = in_fill ? cnt : word_q;
  assign cram_wr_data = (in_fill && !(pl_q.merge && fill_hit_word)) ?
                        mem_rd_data : wdata_q;

endmodule

// File: rtl/clc_chk.sv
module clc_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic             busy,
  input logic             done,
  input logic [1:0]       line_state,
  input logic             mem_rd_req,
  input logic             mem_rd_ack,
  input logic [IDX_W-1:0] mem_rd_word,
  input logic             mem_wr_req,
  input logic             mem_wr_ack,
  input logic [IDX_W-1:0] mem_wr_word,
  input logic             mem_wr_line
);

  logic [2:0] op_t;
  logic       dirty_t;
  logic       drained_t;
  logic       take;

  assign take = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_t      <= 3'd0;
      dirty_t   <= 1'b0;
      drained_t <= 1'b0;
    end else begin
      if (take) begin
        op_t    <= req_op;
        dirty_t <= (line_state == 2'b11);
      end
      if (take) drained_t <= 1'b0;
      else if (mem_wr_req && mem_wr_line) drained_t <= 1'b1;
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(line_state));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_word)));

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=>
      (mem_wr_req && $stable(mem_wr_word) && $stable(mem_wr_line)));

  // R12
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  // R8
  drain_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drained_t |-> !mem_rd_req);

  // R10
  inval_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_t == 3'd2) |-> (!mem_wr_req && !mem_rd_req));

  // R11
  clean_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_t == 3'd3 || op_t == 3'd4) && !dirty_t) |-> !mem_wr_req);

endmodule

bind cache_line_ctrl clc_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_cache_line_ctrl.sv
module test_cache_line_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic        req_hit = 1'b0;
  logic        req_copyback = 1'b0;
  logic [1:0]  req_word = 2'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        busy, done, rd_valid;
  logic [31:0] rd_data;
  logic [1:0]  line_state;
  logic        mem_rd_req;
  logic [1:0]  mem_rd_word;
  logic [31:0] mem_rd_data;
  logic        mem_rd_ack = 1'b0;
  logic        mem_wr_req, mem_wr_line;
  logic [1:0]  mem_wr_word;
  logic [31:0] mem_wr_data;
  logic        mem_wr_ack = 1'b0;
  logic [1:0]  cram_rd_word;
  logic [31:0] cram_rd_data;
  logic        cram_wr_en;
  logic [1:0]  cram_wr_word;
  logic [31:0] cram_wr_data;

  logic [31:0] cram [4];
  logic [31:0] fill_mem [4];
  logic [31:0] snap [4];

  int unsigned cyc = 0;
  int          rd_cnt, wr_cnt, ret_cnt, done_cnt;
  logic [1:0]  rd_log [16];
  logic [1:0]  wr_word_log [16];
  logic [31:0] wr_data_log [16];
  logic        wr_line_log [16];
  logic [31:0] ret_val;
  int unsigned fill_last, drain_first;
  int          errors = 0;
  int          checks = 0;

  always #10 clk = ~clk;

  assign mem_rd_data  = fill_mem[mem_rd_word];
  assign cram_rd_data = cram[cram_rd_word];

  cache_line_ctrl i_cache_line_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_hit(req_hit), .req_copyback(req_copyback), .req_word(req_word),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_valid(rd_valid),
    .rd_data(rd_data), .line_state(line_state), .mem_rd_req(mem_rd_req),
    .mem_rd_word(mem_rd_word), .mem_rd_data(mem_rd_data),
    .mem_rd_ack(mem_rd_ack), .mem_wr_req(mem_wr_req),
    .mem_wr_line(mem_wr_line), .mem_wr_word(mem_wr_word),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .cram_rd_word(cram_rd_word), .cram_rd_data(cram_rd_data),
    .cram_wr_en(cram_wr_en), .cram_wr_word(cram_wr_word),
    .cram_wr_data(cram_wr_data)
  );

  // Memory and cache-RAM model: acks every other cycle; events of the
  // coming rising edge are recorded just after the falling edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_rd_ack = mem_rd_req && !mem_rd_ack;
    mem_wr_ack = mem_wr_req && !mem_wr_ack;
    #1;
    if (mem_rd_ack && rd_cnt < 16) begin
      rd_log[rd_cnt] = mem_rd_word;
      rd_cnt = rd_cnt + 1;
      fill_last = cyc;
    end
    if (mem_wr_ack && wr_cnt < 16) begin
      wr_word_log[wr_cnt] = mem_wr_word;
      wr_data_log[wr_cnt] = mem_wr_data;
      wr_line_log[wr_cnt] = mem_wr_line;
      if (mem_wr_line && drain_first == 0) drain_first = cyc;
      wr_cnt = wr_cnt + 1;
    end
    if (cram_wr_en) cram[cram_wr_word] = cram_wr_data;
    if (rd_valid) begin
      ret_cnt = ret_cnt + 1;
      ret_val = rd_data;
    end
    if (done) done_cnt = done_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    rd_cnt = 0; wr_cnt = 0; ret_cnt = 0; done_cnt = 0;
    fill_last = 0; drain_first = 0; ret_val = 32'hx;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 300) begin
      @(negedge clk);
      n = n + 1;
    end
    repeat (3) @(negedge clk);
    #2;
  endtask

  task automatic issue(input logic [2:0] op, input logic hit, input logic cb,
                       input logic [1:0] w, input logic [31:0] d);
    clear_logs();
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_hit = hit;
    req_copyback = cb; req_word = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_op(input logic [2:0] op, input logic hit, input logic cb,
                       input logic [1:0] w, input logic [31:0] d);
    issue(op, hit, cb, w, d);
    wait_done();
  endtask

  task automatic set_fill(input logic [31:0] base);
    for (int i = 0; i < 4; i++) fill_mem[i] = base + 32'(i);
  endtask

  task automatic take_snap();
    for (int i = 0; i < 4; i++) snap[i] = cram[i];
  endtask

  task automatic chk_drain(input string tag);
    chk(tag, 32'(wr_cnt), 32'd4, "line write count");
    for (int i = 0; i < 4; i++) begin
      chk(tag, {30'd0, wr_word_log[i]}, 32'(i), "drain word order");
      chk(tag, wr_data_log[i], snap[i], "drain data is victim");
      chk(tag, {31'd0, wr_line_log[i]}, 32'd1, "drain marked as line");
    end
  endtask

  task automatic t_reset();
    #2;
    chk("R1", {30'd0, line_state}, 32'd0, "state after reset");
    chk("R1", {28'd0, busy, done, mem_rd_req, mem_wr_req}, 32'd0,
        "busy/done/requests after reset");
  endtask

  task automatic t_read_miss_clean();
    set_fill(32'hA000_0000);
    do_op(3'd0, 1'b0, 1'b1, 2'd2, 32'd0);
    chk("R2", 32'(rd_cnt), 32'd4, "fill word count");
    for (int i = 0; i < 4; i++) begin
      chk("R2", {30'd0, rd_log[i]}, 32'(i), "fill order");
      chk("R2", cram[i], fill_mem[i], "cache filled");
    end
    chk("R2", ret_val, 32'hA000_0002, "returned word");
    chk("R2", 32'(wr_cnt), 32'd0, "no memory write");
    chk("R2", {30'd0, line_state}, 32'b10, "ends Valid");
    chk("R12", 32'(done_cnt), 32'd1, "one done pulse");
  endtask

  task automatic t_read_hit();
    do_op(3'd0, 1'b1, 1'b0, 2'd1, 32'd0);
    chk("R3", ret_val, cram[1], "hit data");
    chk("R3", 32'(ret_cnt), 32'd1, "one return strobe");
    chk("R3", 32'(rd_cnt + wr_cnt), 32'd0, "no memory traffic");
    chk("R3", {30'd0, line_state}, 32'b10, "state kept");
  endtask

  task automatic t_wt_miss(input logic [1:0] exp_state);
    take_snap();
    do_op(3'd1, 1'b0, 1'b0, 2'd3, 32'hD00D_0003);
    chk("R5", 32'(wr_cnt), 32'd1, "single write count");
    chk("R5", {30'd0, wr_word_log[0]}, 32'd3, "write word");
    chk("R5", wr_data_log[0], 32'hD00D_0003, "write data");
    chk("R5", {31'd0, wr_line_log[0]}, 32'd0, "single-word kind");
    chk("R5", cram[3], snap[3], "cache untouched");
    chk("R5", 32'(rd_cnt), 32'd0, "no fill");
    chk("R5", {30'd0, line_state}, {30'd0, exp_state}, "state kept");
  endtask

  task automatic t_cb_hit(input logic [1:0] w, input logic [31:0] d);
    do_op(3'd1, 1'b1, 1'b1, w, d);
    chk("R6", cram[w], d, "cache word written");
    chk("R6", 32'(rd_cnt + wr_cnt), 32'd0, "no memory traffic");
    chk("R6", {30'd0, line_state}, 32'b11, "ends Modified");
  endtask

  task automatic t_read_miss_dirty();
    take_snap();
    set_fill(32'hB000_0000);
    do_op(3'd0, 1'b0, 1'b0, 2'd1, 32'd0);
    chk_drain("R8");
    chk("R8", 32'(rd_cnt), 32'd4, "fill count");
    chk("R8", 32'(drain_first > fill_last), 32'd1, "drain after fill");
    chk("R8", ret_val, 32'hB000_0001, "returned new word");
    chk("R8", cram[3], 32'hB000_0003, "new line in cache");
    chk("R8", {30'd0, line_state}, 32'b10, "ends Valid");
    chk("R12", 32'(done_cnt), 32'd1, "one done after drain");
  endtask

  task automatic t_cb_miss_dirty();
    take_snap();
    set_fill(32'hC000_0000);
    do_op(3'd1, 1'b0, 1'b1, 2'd0, 32'hF00F_0000);
    chk_drain("R9");
    chk("R9", 32'(drain_first > fill_last), 32'd1, "drain after fill");
    chk("R9", cram[0], 32'hF00F_0000, "write merged");
    chk("R9", cram[2], 32'hC000_0002, "other words fetched");
    chk("R9", 32'(ret_cnt), 32'd0, "no data return");
    chk("R9", {30'd0, line_state}, 32'b11, "stays Modified");
  endtask

  task automatic t_wt_hit_dirty();
    do_op(3'd1, 1'b1, 1'b0, 2'd1, 32'h6666_0001);
    chk("R7", 32'(wr_cnt), 32'd1, "memory write count");
    chk("R7", wr_data_log[0], 32'h6666_0001, "memory write data");
    chk("R7", {30'd0, wr_word_log[0]}, 32'd1, "memory write word");
    chk("R7", cram[1], 32'h6666_0001, "cache written");
    chk("R7", {30'd0, line_state}, 32'b10, "demoted to Valid");
  endtask

  task automatic t_inval();
    do_op(3'd2, 1'b1, 1'b0, 2'd0, 32'd0);
    chk("R10", 32'(rd_cnt + wr_cnt), 32'd0, "no memory traffic");
    chk("R10", {30'd0, line_state}, 32'b00, "ends Invalid");
  endtask

  task automatic t_cb_miss_inv();
    set_fill(32'hE000_0000);
    do_op(3'd1, 1'b0, 1'b1, 2'd2, 32'h1234_5678);
    chk("R4", 32'(rd_cnt), 32'd4, "fill count");
    chk("R4", cram[2], 32'h1234_5678, "write merged");
    chk("R4", cram[1], 32'hE000_0001, "fetched word");
    chk("R4", 32'(wr_cnt), 32'd0, "no memory write");
    chk("R4", {30'd0, line_state}, 32'b11, "ends Modified");
  endtask

  task automatic t_push();
    take_snap();
    do_op(3'd3, 1'b1, 1'b0, 2'd0, 32'd0);
    chk_drain("R11");
    chk("R11", {30'd0, line_state}, 32'b10, "push ends Valid");
    do_op(3'd3, 1'b1, 1'b0, 2'd0, 32'd0);
    chk("R11", 32'(wr_cnt), 32'd0, "clean push quiet");
    chk("R11", {30'd0, line_state}, 32'b10, "clean push keeps Valid");
    do_op(3'd4, 1'b1, 1'b0, 2'd0, 32'd0);
    chk("R11", 32'(wr_cnt), 32'd0, "clean push-inv quiet");
    chk("R11", {30'd0, line_state}, 32'b00, "clean push-inv Invalid");
    do_op(3'd3, 1'b0, 1'b0, 2'd0, 32'd0);
    chk("R11", 32'(wr_cnt), 32'd0, "push on Invalid quiet");
    chk("R11", {30'd0, line_state}, 32'b00, "push keeps Invalid");
    set_fill(32'h7000_0000);
    do_op(3'd0, 1'b0, 1'b0, 2'd0, 32'd0);
    t_cb_hit(2'd3, 32'h7777_7777);
    take_snap();
    do_op(3'd4, 1'b1, 1'b0, 2'd0, 32'd0);
    chk_drain("R11");
    chk("R11", {30'd0, line_state}, 32'b00, "dirty push-inv Invalid");
  endtask

  task automatic t_busy_ignore();
    set_fill(32'h9000_0000);
    issue(3'd0, 1'b0, 1'b0, 2'd3, 32'd0);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd2;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk("R12", 32'(done_cnt), 32'd1, "busy request ignored: one done");
    chk("R12", {30'd0, line_state}, 32'b10, "busy request ignored: state");
    chk("R12", ret_val, 32'h9000_0003, "busy request ignored: data");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      cram[i] = 32'h5500_0000 + 32'(i);
      fill_mem[i] = 32'd0;
    end
    clear_logs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_read_miss_clean();
    t_read_hit();
    t_wt_miss(2'b10);
    t_cb_hit(2'd3, 32'hEEEE_0003);
    t_wt_miss(2'b11);
    t_read_miss_dirty();
    t_cb_hit(2'd2, 32'hAAAA_0002);
    t_cb_miss_dirty();
    t_wt_hit_dirty();
    t_cb_hit(2'd0, 32'hBBBB_0000);
    t_inval();
    t_cb_miss_inv();
    t_push();
    do_op(3'd2, 1'b0, 1'b0, 2'd0, 32'd0);
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule